// File: doc/BRIEF.md
# Area-Based Per-Chip Refresh Scheduler

This block sits beside a memory controller's own refresh row counter and decides, row by row, which DRAM chips of one rank get a manual refresh (an activate/precharge pair sent to that row). The rank is split into memory areas. Each area is a run of consecutive rows, and each has its own refresh rate for every chip. A rank's chips can hold bits of different importance, so each chip can be given its own rate: chips holding high-order data can be refreshed often, chips holding low-order data less often, and chips that need no refresh can be skipped.

The areas live in a small single-ported table, stored in row order. Each entry holds:
- the last row of its area;
- for every chip, a countdown (phase) and a reload value (period), both counted in whole base refresh periods.

The scheduler walks this table in step with its row cursor. When the cursor enters an area, the scheduler reads the entry, updates every chip's phase, and writes the entry back. It then offers one command per row to the downstream command path on a valid/ready stream. Each command carries the row and a mask of the chips to select. A row whose mask is empty produces no command.

Software loads the table through a plain write port while the scheduler is disabled. The offer stream follows the usual back-pressure rules: once a command is offered, it is held unchanged until ready is seen high. The scheduler does not move on to the next row until that offer has been accepted.

Top module: `area_refresh_sched`

## Requirements
- R1: After reset, no command is offered (`ref_valid` low), the cursor is at row 0 and entry 0, and the scheduler stays quiet while `en` is low.
- R2: Entry k covers the rows after the previous entry's last row, up to and including its own `end` row. The entry index advances by one, modulo N_AREAS, after the row equal to the current entry's `end` is served.
- R3: Each time an area is entered, each chip with a nonzero period is updated as follows. If its stored phase is at or below 1, the chip is selected for every row of that area and its phase is reloaded from its period. Otherwise the chip is not selected and its phase is decremented by one. The updated phases are written back to the entry.
- R4: A period of 0 means the chip is never selected in that area, and its phase is left unchanged.
- R5: After row N_ROWS-1 has been served, the cursor returns to row 0 and entry 0, whatever the current entry's `end` value.
- R6: The scheduler makes one offer per row whose mask is nonzero. Mask bit i selects chip i. An offer holds `ref_row` and `ref_mask` stable until `ref_ready` is sampled high. Rows with an empty mask are skipped without an offer.
- R7: A configuration write stores `{cfg_end, cfg_period, cfg_phase}` at entry `cfg_idx` only while `en` is low and the scheduler is idle. At any other time the write is ignored. Chip i's phase is at `cfg_phase[i*CNT_W +: CNT_W]`, and its period is at the same position in `cfg_period`.
- R8: Raising `en` starts a walk at row 0 and entry 0. Lowering `en` stops the scheduler once the current row has completed, including any offer already made. After that, no new offer is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Scheduler enable |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_end | input | ROW_W | Last row of the area |
| cfg_phase | input | N_CHIPS*CNT_W | Per-chip starting phases |
| cfg_period | input | N_CHIPS*CNT_W | Per-chip periods, 0 = never refresh |
| ref_valid | output | 1 | Refresh command offered |
| ref_ready | input | 1 | Command path accepts the offer |
| ref_row | output | ROW_W | Row to refresh |
| ref_mask | output | N_CHIPS | Chip-select mask, bit i = chip i |

## Verification
The bench builds the scheduler with 16 rows, 4 chips, 4 table entries and 4-bit counters. With these sizes, a full pass over the device takes only a few dozen cycles. Several passes therefore fit in one scenario, which is enough to see a period-3 chip fire on every third pass, see the entry index wrap, and reach the device wrap at row 15. The small table also makes it cheap to test single-row areas at rows 0 and 1, an area in which every chip is idle, and a phase of 0 that fires at once. Randomised back-pressure holds offers open for several cycles in most scenarios.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_UPD,
    ST_SERVE
  } rs_state_e;
endpackage

// File: rtl/rs_entry_ram.sv
module rs_entry_ram #(
  parameter int W = 40,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // One port: a write and a registered read share the address.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/rs_chip_phase.sv
module rs_chip_phase #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] phase,
  input  logic [CNT_W-1:0] period,
  output logic             fire,
  output logic [CNT_W-1:0] phase_nx
);
  always_comb begin
    fire     = 1'b0;
    phase_nx = phase;
    if (period != '0) begin
      if (phase <= CNT_W'(1)) begin
        fire     = 1'b1;
        phase_nx = period;
      end else begin
        phase_nx = phase - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_row_cursor.sv
module rs_row_cursor #(
  parameter int N_ROWS = 1024,
  parameter int N_AREAS = 16,
  localparam int ROW_W = $clog2(N_ROWS),
  localparam int IDX_W = $clog2(N_AREAS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [ROW_W-1:0] end_row,
  output logic [ROW_W-1:0] row,
  output logic [IDX_W-1:0] idx,
  output logic             area_done
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(N_ROWS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_AREAS - 1);

  logic at_end, at_last;
  assign at_end    = (row == end_row);
  assign at_last   = (row == LAST_ROW);
  assign area_done = at_end | at_last;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      row <= '0;
      idx <= '0;
    end else if (step) begin
      if (at_last) begin
        row <= '0;
        idx <= '0;
      end else begin
        row <= row + 1'b1;
        if (at_end) idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/area_refresh_sched.sv
module area_refresh_sched #(
  parameter int N_ROWS = 1024,
  parameter int N_CHIPS = 8,
  parameter int N_AREAS = 16,
  parameter int CNT_W = 4,
  localparam int ROW_W = $clog2(N_ROWS),
  localparam int IDX_W = $clog2(N_AREAS),
  localparam int VEC_W = N_CHIPS * CNT_W,
  localparam int ENT_W = ROW_W + 2 * VEC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [ROW_W-1:0]   cfg_end,
  input  logic [VEC_W-1:0]   cfg_phase,
  input  logic [VEC_W-1:0]   cfg_period,
  output logic               ref_valid,
  input  logic               ref_ready,
  output logic [ROW_W-1:0]   ref_row,
  output logic [N_CHIPS-1:0] ref_mask
);
  import rs_pkg::*;

  rs_state_e st_q, st_d;

  logic [IDX_W-1:0]   ram_addr, idx;
  logic               ram_we;
  logic [ENT_W-1:0]   ram_wdata, ram_rdata;
  logic [ROW_W-1:0]   rd_end, end_q, row;
  logic [VEC_W-1:0]   rd_phase, rd_period, nx_phase;
  logic [N_CHIPS-1:0] fire, mask_q;
  logic               cfg_ok, advance, area_done;

  assign {rd_end, rd_period, rd_phase} = ram_rdata;

  for (genvar g = 0; g < N_CHIPS; g++) begin : g_chip
    rs_chip_phase #(.CNT_W(CNT_W)) u_phase (
      .phase   (rd_phase[g*CNT_W +: CNT_W]),
      .period  (rd_period[g*CNT_W +: CNT_W]),
      .fire    (fire[g]),
      .phase_nx(nx_phase[g*CNT_W +: CNT_W])
    );
  end

  // Table port shared between loading and the read-modify-write walk.
  assign cfg_ok    = (st_q == ST_IDLE) && !en;
  assign ram_addr  = cfg_ok ? cfg_idx : idx;
  assign ram_we    = (cfg_ok && cfg_we) || (st_q == ST_UPD);
  assign ram_wdata = cfg_ok ? {cfg_end, cfg_period, cfg_phase}
                            : {rd_end, rd_period, nx_phase};

  rs_entry_ram #(.W(ENT_W), .DEPTH(N_AREAS)) u_ram (
    .clk  (clk),
    .addr (ram_addr),
    .we   (ram_we),
    .wdata(ram_wdata),
    .rdata(ram_rdata)
  );

  assign advance = (st_q == ST_SERVE) && (!(|mask_q) || ref_ready);

  rs_row_cursor #(.N_ROWS(N_ROWS), .N_AREAS(N_AREAS)) u_cursor (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (st_q == ST_IDLE),
    .step     (advance),
    .end_row  (end_q),
    .row      (row),
    .idx      (idx),
    .area_done(area_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (en) st_d = ST_READ;
      ST_READ:  st_d = en ? ST_UPD : ST_IDLE;
      ST_UPD:   st_d = en ? ST_SERVE : ST_IDLE;
      ST_SERVE: if (advance) begin
                  if (!en) st_d = ST_IDLE;
                  else if (area_done) st_d = ST_READ;
                end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      end_q  <= '0;
      mask_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_UPD) begin
        end_q  <= rd_end;
        mask_q <= fire;
      end
    end
  end

  assign ref_valid = (st_q == ST_SERVE) && (|mask_q);
  assign ref_row   = row;
  assign ref_mask  = mask_q;
endmodule

// File: rtl/rs_sched_chk.sv
module rs_sched_chk #(
  parameter int N_CHIPS = 8,
  parameter int ROW_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               ref_valid,
  input logic               ref_ready,
  input logic [ROW_W-1:0]   ref_row,
  input logic [N_CHIPS-1:0] ref_mask
);
  // R6
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && !ref_ready |=> ref_valid && $stable(ref_row) && $stable(ref_mask));

  // R6
  nonzero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |-> ref_mask != '0);

  // R6
  row_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && ref_ready |=> !ref_valid || ref_row != $past(ref_row));

  // R8
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !ref_valid |=> !ref_valid);
endmodule

bind area_refresh_sched rs_sched_chk #(.N_CHIPS(N_CHIPS), .ROW_W(ROW_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .ref_valid(ref_valid),
  .ref_ready(ref_ready),
  .ref_row  (ref_row),
  .ref_mask (ref_mask)
);

// File: tb/tb_area_refresh_sched.sv
module tb_area_refresh_sched;
  localparam int N_ROWS = 16, N_CHIPS = 4, N_AREAS = 4, CNT_W = 4;
  localparam int ROW_W = 4, IDX_W = 2, VEC_W = N_CHIPS * CNT_W;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, en = 1'b0, cfg_we = 1'b0, ref_ready = 1'b1;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [ROW_W-1:0] cfg_end = '0;
  logic [VEC_W-1:0] cfg_phase = '0, cfg_period = '0;
  logic ref_valid;
  logic [ROW_W-1:0] ref_row;
  logic [N_CHIPS-1:0] ref_mask;

  area_refresh_sched #(.N_ROWS(N_ROWS), .N_CHIPS(N_CHIPS), .N_AREAS(N_AREAS), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_end(cfg_end), .cfg_phase(cfg_phase), .cfg_period(cfg_period),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_row(ref_row), .ref_mask(ref_mask)
  );

  int checks = 0, fails = 0, cycles = 0;
  int exp_count = 0, got_count = 0;
  string tag = "";
  logic [ROW_W+N_CHIPS-1:0] sb_q[$];
  int ends[N_AREAS];
  int ph[N_AREAS][N_CHIPS];
  int per[N_AREAS][N_CHIPS];
  logic bp = 1'b0;
  logic [7:0] lfsr = 8'h5A;

  // Back-pressure source, changed away from the sampling edge.
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ref_ready = bp ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // Monitor: offer stability (R6) and scoreboard comparison.
  logic held = 1'b0;
  logic [ROW_W-1:0] h_row = '0;
  logic [N_CHIPS-1:0] h_mask = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        checks++;
        if (!ref_valid || ref_row != h_row || ref_mask != h_mask) begin
          fails++;
          $display("FAIL R6 held offer changed: got v=%0b row=%0d mask=%b exp row=%0d mask=%b",
                   ref_valid, ref_row, ref_mask, h_row, h_mask);
        end
      end
      held   = ref_valid && !ref_ready;
      h_row  = ref_row;
      h_mask = ref_mask;
      if (ref_valid && ref_ready && got_count < exp_count) begin
        logic [ROW_W+N_CHIPS-1:0] item;
        item = sb_q.pop_front();
        got_count++;
        checks++;
        if ({ref_row, ref_mask} !== item) begin
          fails++;
          $display("FAIL %s command: got row=%0d mask=%b exp row=%0d mask=%b",
                   tag, ref_row, ref_mask, item[ROW_W+N_CHIPS-1:N_CHIPS], item[N_CHIPS-1:0]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired: got %0d commands exp %0d", got_count, exp_count);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d exp %0d", what, got, exp);
    end
  endtask

  task automatic load_entry(input int i, input int e, input logic [VEC_W-1:0] phv,
                            input logic [VEC_W-1:0] perv);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_idx = IDX_W'(i); cfg_end = ROW_W'(e);
    cfg_phase = phv; cfg_period = perv;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    ends[i] = e;
    for (int c = 0; c < N_CHIPS; c++) begin
      ph[i][c]  = int'(phv[c*CNT_W +: CNT_W]);
      per[i][c] = int'(perv[c*CNT_W +: CNT_W]);
    end
  endtask

  // Expected command stream, built from R2..R6.
  task automatic model_passes(input int passes);
    for (int p = 0; p < passes; p++) begin
      int row;
      int ptr;
      bit done;
      row = 0; ptr = 0; done = 1'b0;
      while (!done) begin
        logic [N_CHIPS-1:0] m;
        bit leave;
        m = '0;
        leave = 1'b0;
        for (int c = 0; c < N_CHIPS; c++) begin
          if (per[ptr][c] != 0) begin
            if (ph[ptr][c] <= 1) begin
              m[c] = 1'b1;
              ph[ptr][c] = per[ptr][c];
            end else begin
              ph[ptr][c] = ph[ptr][c] - 1;
            end
          end
        end
        while (!leave) begin
          if (m != '0) begin
            sb_q.push_back({ROW_W'(row), m});
            exp_count++;
          end
          if (row == N_ROWS - 1) begin
            leave = 1'b1;
            done = 1'b1;
          end else begin
            if (row == ends[ptr]) begin
              ptr = (ptr + 1) % N_AREAS;
              leave = 1'b1;
            end
            row++;
          end
        end
      end
    end
  endtask

  task automatic run(input int passes, input bit use_bp, input bit poke, input string t);
    tag = t;
    bp = use_bp;
    model_passes(passes);
    @(posedge clk); #1;
    en = 1'b1;
    if (poke) begin
      // R7: a write while enabled must not disturb the stream.
      repeat (6) @(posedge clk);
      #1;
      cfg_we = 1'b1; cfg_idx = 2'd1; cfg_end = 4'd2;
      cfg_phase = '1; cfg_period = 16'h1111;
      @(posedge clk); #1;
      cfg_we = 1'b0;
    end
    while (got_count < exp_count) @(posedge clk);
    #1;
    en = 1'b0;
    bp = 1'b0;
    repeat (30) @(posedge clk);
    @(negedge clk);
    check(!ref_valid, {"R8 quiet after disable (", t, ")"}, int'(ref_valid), 0);
    check(sb_q.size() == 0, {"R6 command count (", t, ")"}, sb_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle after reset with en low.
    check(!ref_valid, "R1 no offer after reset", int'(ref_valid), 0);

    // S1: mixed rates, never-refresh chip, empty area, four passes (R2 R3 R4).
    load_entry(0, 3,  16'h1231, 16'h2130);
    load_entry(1, 7,  16'h0000, 16'h0000);
    load_entry(2, 11, 16'h4321, 16'h4321);
    load_entry(3, 15, 16'h1111, 16'h0102);
    run(4, 1'b1, 1'b0, "R2 R3 R4");

    // S2: reload and poke the table while enabled (R7).
    load_entry(0, 3,  16'h1231, 16'h2130);
    load_entry(1, 7,  16'h0000, 16'h0000);
    load_entry(2, 11, 16'h4321, 16'h4321);
    load_entry(3, 15, 16'h1111, 16'h0102);
    run(2, 1'b1, 1'b1, "R7");

    // S3: one area spanning the device, every chip every pass (R5 R6).
    load_entry(0, 15, 16'h1111, 16'h1111);
    load_entry(1, 15, 16'h3333, 16'h0000);
    load_entry(2, 15, 16'h3333, 16'h0000);
    load_entry(3, 15, 16'h3333, 16'h0000);
    run(2, 1'b0, 1'b0, "R5 R6");

    // S4: single-row areas at rows 0 and 1, phase 0 fires at once (R2 R3 R5).
    load_entry(0, 0,  16'h1111, 16'h2222);
    load_entry(1, 1,  16'h2222, 16'h1111);
    load_entry(2, 14, 16'h1212, 16'h3333);
    load_entry(3, 15, 16'h0000, 16'h0001);
    run(3, 1'b1, 1'b0, "R2 R3 R5 r8_restart");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule